// File: doc/BRIEF.md
# Deflection Controller Register Slave with Standby-Gated Acknowledge

This block is the write-only two-wire serial slave that loads the control registers of a monitor deflection controller. A host sends a START, a 7-bit device address with the write direction, one subaddress byte and any number of data bytes, then a STOP. Each data byte lands at the current subaddress. The subaddress then steps by one, so a burst fills neighbouring registers. SCL and SDA are oversampled by a fast system clock. SDA is driven open-drain: the block only ever pulls it low during an acknowledge slot.

The block has an active mode and a standby mode. It comes out of reset in standby, and a supply-dip input forces it back there at any time. In standby the device address and the subaddress are still acknowledged. Data bytes are refused and not stored, except for bytes aimed at the mode control register at subaddress 1AH. A host can therefore learn the mode by writing a harmless byte to any ordinary register and seeing whether the data byte is acknowledged. It restarts the device by writing the control register. A soft-start request produces a one-cycle pulse and leaves standby.

Top module: `defl_i2c_regslave`

## Requirements
- R1: After reset every register reads 0, `standby_o` is 1, `soft_start_o` is 0 and `sda_oe_o` is 0.
- R2: The address byte is acknowledged only when its upper seven bits equal `DEV_ADDR` and its last bit (R/W) is 0. Otherwise no byte of that transfer is acknowledged and nothing is stored until the next START or STOP.
- R3: After a matching address byte, the subaddress byte is always acknowledged, whatever the mode.
- R4: In active mode a data byte whose subaddress is below `NUM_REGS` is acknowledged and stored in that register, visible on `regs_o[8*sub +: 8]`.
- R5: In standby a data byte for any subaddress other than `CTRL_IDX` (1AH) is not acknowledged and not stored, and the rest of that transfer is ignored. A data byte for 1AH is acknowledged and stored in either mode.
- R6: In the control register, bit 0 is the standby request and bit 1 is the soft-start request. A write with bit 0 = 1 enters standby. A write with bit 0 = 0 and bit 1 = 1 leaves standby and raises `soft_start_o` for exactly one clock. A write with both bits 0 leaves the mode unchanged.
- R7: Within one transfer, each accepted data byte advances the subaddress by one.
- R8: A data byte whose subaddress is `NUM_REGS` or higher is not acknowledged and not stored.
- R9: While `pwr_dip_i` is 1, `standby_o` is 1 from the next clock on. After release, the device stays in standby until a soft-start write.
- R10: When `pwr_dip_i` is 1 in the cycle a control write is committed, the byte is stored but the device does not leave standby and gives no soft-start pulse.
- R11: A START or STOP in the middle of a byte discards the partial byte. The next transfer decodes from its first bit.
- R12: `sda_oe_o` goes high only while SCL is low before an acknowledge slot, and it is low during every address, subaddress and data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| pwr_dip_i | input | 1 | Supply dip indication, synchronous to clk; forces standby |
| regs_o | output | NUM_REGS*8 | Register contents, register k at bits 8k+7..8k |
| soft_start_o | output | 1 | One-clock pulse on an accepted soft-start request |
| standby_o | output | 1 | 1 while the device is in standby |

## Verification
Two events can fall in the same clock: a supply dip and the commit of a soft-start byte to the control register. The bench raises `pwr_dip_i` in active mode and keeps it high across a complete write of a soft-start byte to 1AH. The commit cycle therefore always sees the dip. The reference model expects the byte to be acknowledged and stored, `standby_o` to stay high and no soft-start pulse to be counted. A behavioural model of registers and mode is compared with the outputs on every clock, outside the few cycles where a commit is in flight.

// File: rtl/defl_i2c_pkg.sv
// Package: shared types and constants for the deflection-controller register slave.
// Assumes: byte-wide registers and one control register holding the mode bits.
package defl_i2c_pkg;

    // Protocol phase of the byte engine
    typedef enum logic [2:0] {
        BUS_IDLE = 3'd0,
        BUS_ADDR = 3'd1,
        BUS_SUB  = 3'd2,
        BUS_DATA = 3'd3,
        BUS_SKIP = 3'd4
    } bus_st_t;

    // Bit positions inside the control register
    localparam int CTRL_STBY_BIT = 0;
    localparam int CTRL_SOFT_BIT = 1;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/defl_line_sync.sv
// Module: defl_line_sync
// Brings SCL/SDA into the clk domain and detects SCL edges and START/STOP.
// Assumes: clk is several times faster than SCL; SYNC_STAGES >= 2.
module defl_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    // Synchronizer chains; the idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_pipe[SYNC_STAGES-1];
            sda_d <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_s_o    = scl_pipe[SYNC_STAGES-1];
        sda_s_o    = sda_pipe[SYNC_STAGES-1];
        scl_rise_o = scl_s_o & ~scl_d;
        scl_fall_o = ~scl_s_o & scl_d;
        start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
        stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
    end

endmodule

// File: rtl/defl_byte_engine.sv
// Module: defl_byte_engine
// Shifts in address, subaddress and data bytes, keeps the auto-incrementing
// subaddress, and drives the acknowledge slot.
// Assumes: synchronized SCL/SDA with single-cycle edge and condition strobes;
// the data acknowledge decision (data_ack_i) is valid in the commit cycle.
module defl_byte_engine
    import defl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s_i,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       data_ack_i,
    output logic [7:0] sub_o,
    output logic [7:0] wdata_o,
    output logic       commit_o,
    output logic       sda_oe_o
);

    bus_st_t    state_q;
    logic [3:0] cnt_q;
    logic       in_ack_q;
    logic       ack_pend_q;
    logic [6:0] shreg_q;
    logic [7:0] sub_q;
    logic       sda_oe_q;
    logic [7:0] byte_w;
    logic       last_bit;
    logic       ack_dec;
    logic       active_ph;

    // Byte being completed and the acknowledge decision for it
    always_comb begin
        byte_w    = {shreg_q, sda_s_i};
        active_ph = (state_q != BUS_IDLE);
        last_bit  = active_ph && scl_rise_i && !in_ack_q && (cnt_q == 4'd7);
        unique case (state_q)
            BUS_ADDR: ack_dec = (byte_w[7:1] == DEV_ADDR) && !byte_w[0];
            BUS_SUB:  ack_dec = 1'b1;
            BUS_DATA: ack_dec = data_ack_i;
            default:  ack_dec = 1'b0;
        endcase
        commit_o = last_bit && (state_q == BUS_DATA);
        wdata_o  = byte_w;
        sub_o    = sub_q;
        sda_oe_o = sda_oe_q;
    end

    // Protocol sequencer: bit counting, acknowledge slot and phase advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= BUS_IDLE;
            cnt_q      <= 4'd0;
            in_ack_q   <= 1'b0;
            ack_pend_q <= 1'b0;
            shreg_q    <= 7'd0;
            sub_q      <= 8'd0;
            sda_oe_q   <= 1'b0;
        end else if (start_i || stop_i) begin
            state_q    <= start_i ? BUS_ADDR : BUS_IDLE;
            cnt_q      <= 4'd0;
            in_ack_q   <= 1'b0;
            ack_pend_q <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else if (active_ph) begin
            if (scl_rise_i && !in_ack_q && (cnt_q != 4'd8)) begin
                shreg_q <= byte_w[6:0];
                cnt_q   <= cnt_q + 4'd1;
            end
            if (last_bit) begin
                ack_pend_q <= ack_dec;
                if (state_q == BUS_SUB) begin
                    sub_q <= byte_w;
                end else if (state_q == BUS_DATA && ack_dec) begin
                    sub_q <= sub_q + 8'd1;
                end
            end
            if (scl_fall_i && !in_ack_q && (cnt_q == 4'd8)) begin
                in_ack_q <= 1'b1;
                sda_oe_q <= ack_pend_q;
            end else if (scl_fall_i && in_ack_q) begin
                in_ack_q <= 1'b0;
                sda_oe_q <= 1'b0;
                cnt_q    <= 4'd0;
                unique case (state_q)
                    BUS_ADDR: state_q <= ack_pend_q ? BUS_SUB : BUS_SKIP;
                    BUS_SUB:  state_q <= BUS_DATA;
                    BUS_DATA: state_q <= ack_pend_q ? BUS_DATA : BUS_SKIP;
                    default:  state_q <= BUS_SKIP;
                endcase
            end
        end
    end

    // R12: the line is only pulled low while SCL is low
    p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_q) |-> !scl_s_i);

    // R11: a START resets the byte engine to a clean address phase
    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == 4'd0 && !sda_oe_q && state_q == BUS_ADDR));

    // R2: a refused transfer never acknowledges
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_SKIP) |-> !sda_oe_q);

endmodule

// File: rtl/defl_reg_bank.sv
// Module: defl_reg_bank
// Holds the byte registers, decides whether a data byte is accepted, and runs
// the standby / soft-start mode control with supply-dip priority.
// Assumes: pwr_dip_i is synchronous to clk; CTRL_IDX < NUM_REGS <= 256.
module defl_reg_bank
    import defl_i2c_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int CTRL_IDX = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            sub_i,
    input  logic [7:0]            wdata_i,
    input  logic                  commit_i,
    input  logic                  pwr_dip_i,
    output logic                  accept_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  standby_o,
    output logic                  soft_start_o
);

    localparam logic [7:0] CTRL_SUB = 8'(CTRL_IDX);

    logic stby_q;
    logic soft_q;
    logic in_range;
    logic is_ctrl;
    logic wr_en;

    // Acceptance of the data byte being committed
    always_comb begin
        in_range = ({24'd0, sub_i} < NUM_REGS);
        is_ctrl  = (sub_i == CTRL_SUB);
        accept_o = in_range && (is_ctrl || (!stby_q && !pwr_dip_i));
        wr_en    = commit_i && accept_o;
    end

    // One storage cell per register
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [7:0] cell_q;

        // Load this cell on an accepted write to its subaddress
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= 8'd0;
            end else if (wr_en && (sub_i == 8'(i))) begin
                cell_q <= wdata_i;
            end
        end

        assign regs_o[i*8 +: 8] = cell_q;
    end

    // Mode control: dip first, then the control-register request bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_q <= 1'b1;
            soft_q <= 1'b0;
        end else begin
            soft_q <= 1'b0;
            if (pwr_dip_i) begin
                stby_q <= 1'b1;
            end else if (wr_en && is_ctrl) begin
                if (wdata_i[CTRL_STBY_BIT]) begin
                    stby_q <= 1'b1;
                end else if (wdata_i[CTRL_SOFT_BIT]) begin
                    stby_q <= 1'b0;
                    soft_q <= 1'b1;
                end
            end
        end
    end

    assign standby_o    = stby_q;
    assign soft_start_o = soft_q;

    // R6: the soft-start pulse lasts one clock and coincides with active mode
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> !soft_q);
    p_pulse_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |-> !stby_q);

    // R9 / R10: a dip always yields standby and no pulse on the next clock
    p_dip_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dip_i |=> (stby_q && !soft_q));

    // R5: an ordinary write in standby leaves every register unchanged
    p_no_store_stby_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && stby_q && !is_ctrl) |=> $stable(regs_o));

endmodule

// File: rtl/defl_i2c_regslave.sv
// Module: defl_i2c_regslave (top)
// Write-only serial register slave with standby-gated data acknowledge.
// Assumes: clk runs at least 8x faster than SCL; SDA is open-drain outside.
module defl_i2c_regslave #(
    parameter logic [6:0] DEV_ADDR    = 7'h46,
    parameter int         NUM_REGS    = 32,
    parameter int         CTRL_IDX    = 26,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  pwr_dip_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  soft_start_o,
    output logic                  standby_o
);

    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       accept;
    logic       commit;
    logic [7:0] sub;
    logic [7:0] wdata;

    defl_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s_o   (scl_s),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    defl_byte_engine #(
        .DEV_ADDR(DEV_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s_i   (scl_s),
        .sda_s_i   (sda_s),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .data_ack_i(accept),
        .sub_o     (sub),
        .wdata_o   (wdata),
        .commit_o  (commit),
        .sda_oe_o  (sda_oe_o)
    );

    defl_reg_bank #(
        .NUM_REGS(NUM_REGS),
        .CTRL_IDX(CTRL_IDX)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .sub_i       (sub),
        .wdata_i     (wdata),
        .commit_i    (commit),
        .pwr_dip_i   (pwr_dip_i),
        .accept_o    (accept),
        .regs_o      (regs_o),
        .standby_o   (standby_o),
        .soft_start_o(soft_start_o)
    );

endmodule

// File: tb/defl_i2c_regslave_tb.sv
// Bench: drives serial write transfers and compares against a behavioural
// model of registers, mode and pulse count on every clock.
module defl_i2c_regslave_tb;

    localparam logic [6:0] DEV = 7'h46;
    localparam int NR   = 32;
    localparam int CTRL = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic pwr_dip = 1'b0;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic soft_start;
    logic standby;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #10 clk = ~clk;

    defl_i2c_regslave #(.DEV_ADDR(DEV), .NUM_REGS(NR), .CTRL_IDX(CTRL)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .pwr_dip_i(pwr_dip), .regs_o(regs),
        .soft_start_o(soft_start), .standby_o(standby)
    );

    int checks = 0;
    int failures = 0;
    int clk_fail_prints = 0;
    bit finished = 0;

    // Reference model state
    logic [7:0] m_regs [NR];
    bit m_stby = 1;
    bit m_dip = 0;
    int m_sub = 0;
    int m_pulses = 0;
    int seen_pulses = 0;
    bit settle = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] model_vec();
        logic [NR*8-1:0] v;
        for (int k = 0; k < NR; k++) v[k*8 +: 8] = m_regs[k];
        return v;
    endfunction

    // Per-clock comparison of registers and mode against the model
    always begin
        @(posedge clk);
        #4;
        if (soft_start) seen_pulses++;
        if (rst_n && !settle && !finished) begin
            checks++;
            if (regs !== model_vec()) begin
                failures++;
                if (clk_fail_prints < 8)
                    $display("FAIL R4 per-cycle regs actual=%h expected=%h", regs, model_vec());
                clk_fail_prints++;
            end
            checks++;
            if (standby !== m_stby) begin
                failures++;
                if (clk_fail_prints < 8)
                    $display("FAIL R9 per-cycle standby actual=%0b expected=%0b", standby, m_stby);
                clk_fail_prints++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; tick(4);
        scl_drv = 1'b1; tick(6);
        sda_drv = 1'b0; tick(6);
        scl_drv = 1'b0; tick(4);
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; tick(4);
        scl_drv = 1'b1; tick(6);
        sda_drv = 1'b1; tick(8);
    endtask

    task automatic send_bit(input bit b);
        sda_drv = b; tick(4);
        scl_drv = 1'b1; tick(8);
        chk(sda_oe == 1'b0, "R12", "sda_oe during bit", int'(sda_oe), 0);
        tick(8);
        scl_drv = 1'b0; tick(4);
    endtask

    // Eight bits; the last one runs with the per-clock compare paused
    task automatic send_bits(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) settle = 1;
            send_bit(v[i]);
        end
    endtask

    task automatic get_ack(output bit acked);
        sda_drv = 1'b1; tick(4);
        scl_drv = 1'b1; tick(8);
        acked = sda_oe;
        tick(8);
        scl_drv = 1'b0; tick(4);
    endtask

    task automatic model_ctrl(input logic [7:0] d);
        if (m_dip) m_stby = 1;
        else if (d[0]) m_stby = 1;
        else if (d[1]) begin m_stby = 0; m_pulses++; end
    endtask

    // START, address and subaddress; returns whether the transfer is live
    task automatic open_txn(input logic [6:0] a, input bit rw, input int sub,
                            output bit alive);
        bit ack;
        bit exp_a;
        i2c_start();
        exp_a = (a == DEV) && !rw;
        send_bits({a, rw}); settle = 0;
        get_ack(ack);
        chk(ack == exp_a, "R2", "address ack", int'(ack), int'(exp_a));
        send_bits(8'(sub)); settle = 0;
        get_ack(ack);
        chk(ack == exp_a, "R3", "subaddress ack", int'(ack), int'(exp_a));
        if (exp_a) m_sub = sub;
        alive = exp_a;
    endtask

    task automatic write_txn(input logic [6:0] a, input bit rw, input int sub,
                             input logic [7:0] d [$], input string req);
        bit alive;
        bit ack;
        bit exp_d;
        open_txn(a, rw, sub, alive);
        foreach (d[j]) begin
            exp_d = alive && (m_sub < NR) && (m_sub == CTRL || (!m_stby && !m_dip));
            send_bits(d[j]);
            tick(2);
            if (exp_d) begin
                m_regs[m_sub] = d[j];
                if (m_sub == CTRL) model_ctrl(d[j]);
                m_sub++;
            end else begin
                alive = 0;
            end
            settle = 0;
            get_ack(ack);
            chk(ack == exp_d, req, "data ack", int'(ack), int'(exp_d));
        end
        i2c_stop();
        tick(4);
        chk(seen_pulses == m_pulses, "R6", "soft-start pulse count", seen_pulses, m_pulses);
    endtask

    task automatic set_dip(input bit v);
        @(negedge clk);
        pwr_dip = v;
        m_dip = v;
        if (v) m_stby = 1;
        tick(3);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit alive;
        for (int k = 0; k < NR; k++) m_regs[k] = 8'h00;
        tick(6);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        chk(regs == '0, "R1", "regs after reset", int'(regs[31:0]), 0);
        chk(standby == 1'b1, "R1", "standby after reset", int'(standby), 1);
        chk(soft_start == 1'b0, "R1", "soft_start after reset", int'(soft_start), 0);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);

        // R5: ordinary write refused in standby
        write_txn(DEV, 0, 5, '{8'h5A}, "R5");
        chk(regs[5*8 +: 8] == 8'h00, "R5", "reg5 untouched in standby", int'(regs[5*8 +: 8]), 0);

        // R5/R6: control accepted in standby, neutral value, next byte refused
        write_txn(DEV, 0, CTRL, '{8'h00, 8'h77}, "R5");
        chk(standby == 1'b1, "R6", "neutral control keeps standby", int'(standby), 1);

        // R2: wrong address, and read direction
        write_txn(7'h47, 0, CTRL, '{8'h02}, "R2");
        write_txn(DEV, 1, CTRL, '{8'h02}, "R2");

        // R6: soft start leaves standby
        write_txn(DEV, 0, CTRL, '{8'h02}, "R6");
        chk(standby == 1'b0, "R6", "active after soft start", int'(standby), 0);

        // R4/R7: burst in active mode
        write_txn(DEV, 0, 5, '{8'h11, 8'h22, 8'h33}, "R7");
        chk(regs[7*8 +: 8] == 8'h33, "R7", "third burst byte at 7", int'(regs[7*8 +: 8]), 8'h33);

        // R8: stepping past the last register
        write_txn(DEV, 0, NR - 1, '{8'hAA, 8'hBB}, "R8");

        // R11: START in the middle of a data byte
        open_txn(DEV, 0, 3, alive);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        write_txn(DEV, 0, 4, '{8'hA5}, "R11");
        chk(regs[3*8 +: 8] == 8'h00, "R11", "partial byte after START dropped", int'(regs[3*8 +: 8]), 0);

        // R11: STOP in the middle of a data byte
        open_txn(DEV, 0, 3, alive);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        i2c_stop();
        tick(4);
        chk(regs[3*8 +: 8] == 8'h00, "R11", "partial byte after STOP dropped", int'(regs[3*8 +: 8]), 0);
        write_txn(DEV, 0, 3, '{8'h3C}, "R11");

        // R6: standby request, then ordinary write refused
        write_txn(DEV, 0, CTRL, '{8'h01}, "R6");
        write_txn(DEV, 0, 2, '{8'h99}, "R5");
        // R6: both bits set, standby request wins
        write_txn(DEV, 0, CTRL, '{8'h03}, "R6");
        chk(standby == 1'b1, "R6", "standby bit wins over soft start", int'(standby), 1);

        // R9: dip forces standby from active
        write_txn(DEV, 0, CTRL, '{8'h02}, "R6");
        set_dip(1);
        chk(standby == 1'b1, "R9", "standby during dip", int'(standby), 1);
        // R10: soft start committed while the dip is high
        write_txn(DEV, 0, CTRL, '{8'h02}, "R10");
        chk(standby == 1'b1, "R10", "dip beats soft start", int'(standby), 1);
        write_txn(DEV, 0, 6, '{8'h44}, "R5");
        set_dip(0);
        tick(10);
        chk(standby == 1'b1, "R9", "standby held after dip release", int'(standby), 1);

        // Recover and write normally
        write_txn(DEV, 0, CTRL, '{8'h02}, "R6");
        write_txn(DEV, 0, 6, '{8'h44}, "R4");
        chk(regs[6*8 +: 8] == 8'h44, "R4", "reg6 after recovery", int'(regs[6*8 +: 8]), 8'h44);

        tick(20);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule